// File: doc/BRIEF.md
# Interleaved Bank Read Command Sequencer

This block generates the command stream for an all-bank interleaved read workload on a DDR3 memory device. Each clock it presents one command on the chip-select, row-strobe, column-strobe and write-enable pins. It also drives the bank address, the row/column address, the clock-enable and termination levels, and the burst data pattern a capture stage should expect for that stretch of the loop. The activate-to-activate spacing and the four-activate window length are run-time inputs counted in clocks.

The loop visits the eight banks in order, one activate every activate-to-activate interval. Each activate is followed on the next clock by a read with auto-precharge to the same bank, and deselects fill the rest of the interval. Groups of four activates are stretched to the window length with deselect padding. Banks 0..3 fill the first window and banks 4..7 the second. For the next two windows the address and data polarity of even and odd sub-loops is swapped. After four windows the loop wraps and repeats for as long as enable is held. When enable drops, the sequencer completes the sub-loop it is in and parks.

Top module: `ileave_rd_seq`

## Requirements
- R1: Command pins {cs_n,ras_n,cas_n,we_n} are 0011 for activate, 0101 for read with addr[10]=1 (auto-precharge), and cs_n=1 for deselect.
- R2: A sub-loop of rrd_cyc clocks issues activate in its first clock, a read to the same bank in its second clock, and deselect in the remaining clocks.
- R3: Within a window, sub-loop k (k=0..3) starts at clock k*rrd_cyc of the window. Windows of even index use banks 0..3 and windows of odd index use banks 4..7. Each window is faw_cyc clocks long, and the first window starts at loop clock 0.
- R4: Clocks from 4*rrd_cyc to faw_cyc-1 of a window are deselects that keep the bank of the window's last sub-loop (3 or 7). No padding clock occurs when 4*rrd_cyc equals faw_cyc.
- R5: In windows 0 and 1, even sub-loops drive addr[6:3]=0 and data_pat=8'h00, and odd sub-loops drive addr[6:3]=4'hF and data_pat=8'h33. All other address bits are 0, except addr[10], which is 1 only on a read.
- R6: In windows 2 and 3 (loop clocks 2*faw_cyc to 4*faw_cyc-1) the even/odd pattern of R5 is swapped. After loop clock 4*faw_cyc-1 the loop resumes at clock 0 with bank 0.
- R7: cke is 1 and odt is 0 at all times.
- R8: cfg_err is 1 whenever rrd_cyc<2 or faw_cyc<4*rrd_cyc. While it is 1, only deselect is driven and no loop runs.
- R9: When en is 0 at the last clock of a sub-loop or at a padding clock, the next clock is idle. Idle drives deselect with bank, addr and data_pat all zero. With en at 1, the clock after an idle clock is loop clock 0 (activate to bank 0).
- R10: While reset is applied, the outputs show the idle state: deselect, bank 0, address 0, data_pat 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run request |
| rrd_cyc | input | CW | Activate-to-activate interval in clocks |
| faw_cyc | input | CW | Four-activate window length in clocks |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| odt | output | 1 | Termination enable, held low |
| bank | output | 3 | Bank address |
| addr | output | 16 | Row/column address |
| data_pat | output | 8 | Expected burst data byte for the current sub-loop |
| cfg_err | output | 1 | Timing inputs are illegal |

## Verification
The bench compares each clock against a model that derives bank, slot and phase by division and remainder of the loop clock. This catches counters that slip by one at the sub-loop or window boundary. It runs the case where 4*rrd_cyc equals faw_cyc: a design that always inserts one padding clock would drift a full clock per window. It also runs odd window lengths that leave several padding clocks, where a design that drops the held bank would show bank 0 instead of 3 or 7. The run passes through the second half of the loop and the wrap, so a missing phase swap shows inverted address and data in windows 2 and 3. Enable is dropped in the middle of a sub-loop and during padding. A design that parks immediately, or that runs on into the next activate, is seen at the pins.

// File: rtl/ileave_pkg.sv
package ileave_pkg;

  typedef enum logic [1:0] {
    CMD_DES = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2
  } cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  function automatic pins_t encode_cmd(cmd_e c);
    pins_t p;
    case (c)
      CMD_ACT: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1};
      CMD_RD:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
      default: p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

endpackage

// File: rtl/ileave_timer.sv
module ileave_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_ok,
  input  logic [CW-1:0] rrd_cyc,
  input  logic [CW-1:0] faw_cyc,
  output logic          run,
  output logic [1:0]    win,
  output logic [1:0]    sub,
  output logic [CW-1:0] slot,
  output logic          pad
);

  logic          run_q, run_d;
  logic [1:0]    win_q, win_d;
  logic [1:0]    sub_q, sub_d;
  logic [CW-1:0] slot_q, slot_d;
  logic [CW-1:0] wpos_q, wpos_d;
  logic          pad_q, pad_d;
  logic          last_slot, end_win, park, adv;

  assign last_slot = (slot_q == rrd_cyc - 1'b1);
  assign end_win   = (wpos_q == faw_cyc - 1'b1);
  assign park      = !cfg_ok || (!en && (pad_q || last_slot));
  assign adv       = run_q || (en && cfg_ok);

  always_comb begin
    run_d  = run_q;
    win_d  = win_q;
    sub_d  = sub_q;
    slot_d = slot_q;
    wpos_d = wpos_q;
    pad_d  = pad_q;
    if (!run_q || park) begin
      run_d  = !run_q && en && cfg_ok;
      win_d  = '0;
      sub_d  = '0;
      slot_d = '0;
      wpos_d = '0;
      pad_d  = 1'b0;
    end else if (end_win) begin
      win_d  = win_q + 2'd1;
      sub_d  = '0;
      slot_d = '0;
      wpos_d = '0;
      pad_d  = 1'b0;
    end else begin
      wpos_d = wpos_q + 1'b1;
      if (!pad_q) begin
        if (last_slot) begin
          if (sub_q == 2'd3) begin
            pad_d = 1'b1;
          end else begin
            slot_d = '0;
            sub_d  = sub_q + 2'd1;
          end
        end else begin
          slot_d = slot_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      win_q  <= '0;
      sub_q  <= '0;
      slot_q <= '0;
      wpos_q <= '0;
      pad_q  <= 1'b0;
    end else if (adv) begin
      run_q  <= run_d;
      win_q  <= win_d;
      sub_q  <= sub_d;
      slot_q <= slot_d;
      wpos_q <= wpos_d;
      pad_q  <= pad_d;
    end
  end

  assign run  = run_q;
  assign win  = win_q;
  assign sub  = sub_q;
  assign slot = slot_q;
  assign pad  = pad_q;

  // R4: the window position never passes the window length
  assert_wpos_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n || !cfg_ok)
    run_q |-> (wpos_q < faw_cyc));

  // R2: the bank of a sub-loop is held for all its clocks
  assert_sub_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && slot_q != '0) |-> (sub_q == $past(sub_q)));

endmodule

// File: rtl/ileave_decode.sv
module ileave_decode #(
  parameter int CW = 8
) (
  input  logic              run,
  input  logic [1:0]        win,
  input  logic [1:0]        sub,
  input  logic [CW-1:0]     slot,
  input  logic              pad,
  output ileave_pkg::cmd_e  cmd,
  output logic [2:0]        bank,
  output logic [15:0]       addr,
  output logic [7:0]        data
);
  import ileave_pkg::*;

  localparam logic [3:0] TOG_NIB = 4'hF;
  localparam logic [7:0] TOG_DAT = 8'h33;

  logic odd;

  assign odd = sub[0] ^ win[1];

  always_comb begin
    cmd  = CMD_DES;
    bank = '0;
    addr = '0;
    data = '0;
    if (run) begin
      if (!pad && slot == '0)
        cmd = CMD_ACT;
      else if (!pad && slot == {{(CW-1){1'b0}}, 1'b1})
        cmd = CMD_RD;
      bank      = {win[0], sub};
      addr[6:3] = odd ? TOG_NIB : 4'h0;
      addr[10]  = (cmd == CMD_RD);
      data      = odd ? TOG_DAT : 8'h00;
    end
  end

endmodule

// File: rtl/ileave_rd_seq.sv
module ileave_rd_seq #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] rrd_cyc,
  input  logic [CW-1:0] faw_cyc,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic          cke,
  output logic          odt,
  output logic [2:0]    bank,
  output logic [15:0]   addr,
  output logic [7:0]    data_pat,
  output logic          cfg_err
);
  import ileave_pkg::*;

  localparam int XW = CW + 2;

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          cfg_ok;
  logic          run, run_eff, pad;
  logic [1:0]    win, sub;
  logic [CW-1:0] slot;
  cmd_e          cmd;
  pins_t         pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign cfg_ok  = (rrd_cyc >= CW'(2)) &&
                   ({2'b00, faw_cyc} >= XW'({rrd_cyc, 2'b00}));
  assign cfg_err = !cfg_ok;

  ileave_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sn),
    .en      (en),
    .cfg_ok  (cfg_ok),
    .rrd_cyc (rrd_cyc),
    .faw_cyc (faw_cyc),
    .run     (run),
    .win     (win),
    .sub     (sub),
    .slot    (slot),
    .pad     (pad)
  );

  assign run_eff = run && cfg_ok;

  ileave_decode #(.CW(CW)) u_decode (
    .run  (run_eff),
    .win  (win),
    .sub  (sub),
    .slot (slot),
    .pad  (pad),
    .cmd  (cmd),
    .bank (bank),
    .addr (addr),
    .data (data_pat)
  );

  assign pins  = encode_cmd(cmd);
  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;
  assign cke   = 1'b1;
  assign odt   = 1'b0;

  // R2: every activate is followed by a read to the same bank
  assert_act_then_read_R2: assert property (@(posedge clk) disable iff (!rst_sn || cfg_err)
    (!cs_n && !ras_n) |=> (!cs_n && ras_n && !cas_n && $stable(bank)));

  // R1: a column command always carries auto-precharge
  assert_read_autopre_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    (!cs_n && !cas_n) |-> (addr[10] && ras_n && we_n));

  // R4: padding clocks are deselects
  assert_pad_deselect_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (run_eff && pad) |-> cs_n);

  // R8: an illegal setting stops the loop at the next clock
  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_sn)
    cfg_err |=> !run);

endmodule

// File: tb/ileave_rd_seq_test.sv
`timescale 1ns/1ps
module ileave_rd_seq_test;

  localparam int CW = 8;
  localparam int NCFG = 5;
  localparam int CFG_TAB [NCFG][2] = '{'{2, 8}, '{2, 11}, '{3, 12}, '{4, 20}, '{5, 21}};

  logic          clk = 1'b0;
  logic          rst_n, en;
  logic [CW-1:0] rrd_cyc, faw_cyc;
  logic          cs_n, ras_n, cas_n, we_n, cke, odt, cfg_err;
  logic [2:0]    bank;
  logic [15:0]   addr;
  logic [7:0]    data_pat;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ileave_rd_seq #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .rrd_cyc(rrd_cyc), .faw_cyc(faw_cyc),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .odt(odt),
    .bank(bank), .addr(addr), .data_pat(data_pat), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] out_word();
    return {cs_n, ras_n, cas_n, we_n, 1'b0, bank, addr, data_pat};
  endfunction

  // expected {pins, 0, bank, addr, data} for loop clock t
  function automatic logic [31:0] model(input int t, input int rrd, input int faw);
    int w, p, s, sl, b;
    bit padc, odd;
    logic [3:0] pins;
    logic [15:0] a;
    w = (t / faw) % 4;
    p = t % faw;
    padc = (p >= 4 * rrd);
    s  = padc ? 3 : p / rrd;
    sl = padc ? 2 : p % rrd;
    odd = ((s % 2) == 1) ^ (w >= 2);
    b = (w % 2) * 4 + s;
    if (!padc && sl == 0) pins = 4'b0011;
    else if (!padc && sl == 1) pins = 4'b0101;
    else pins = 4'b1111;
    a = odd ? 16'h0078 : 16'h0000;
    if (pins == 4'b0101) a[10] = 1'b1;
    return {pins, 1'b0, 3'(b), a, (odd ? 8'h33 : 8'h00)};
  endfunction

  localparam logic [31:0] IDLE_W = {4'b1111, 1'b0, 3'd0, 16'h0000, 8'h00};

  task automatic do_reset(input int rrd, input int faw);
    rst_n = 1'b0;
    en = 1'b0;
    rrd_cyc = CW'(rrd);
    faw_cyc = CW'(faw);
    repeat (2) @(negedge clk);
    // R10: outputs during reset
    chk(out_word() == IDLE_W, "R10 reset idle", out_word(), IDLE_W);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // table walk: R2 R3 R4 R5 R6 R7 R8 R1 over several timings
    for (int i = 0; i < NCFG; i++) begin
      int rrd, faw;
      rrd = CFG_TAB[i][0];
      faw = CFG_TAB[i][1];
      do_reset(rrd, faw);
      chk(cfg_err == 1'b0, "R8 legal config", 32'(cfg_err), 32'd0);
      en = 1'b1;
      for (int t = 0; t < 5 * faw; t++) begin
        @(negedge clk);
        chk(out_word() == model(t, rrd, faw), "R1 R2 R3 R4 R5 R6 loop", out_word(), model(t, rrd, faw));
        chk(cke == 1'b1 && odt == 1'b0, "R7 cke/odt", {cke, odt}, 2'b10);
      end
    end

    // R8: illegal settings
    do_reset(1, 8);
    en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cfg_err && cs_n, "R8 rrd too small", {cfg_err, cs_n}, 2'b11);
    end
    rrd_cyc = 8'd3; faw_cyc = 8'd11;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(cfg_err && cs_n, "R8 faw too small", {cfg_err, cs_n}, 2'b11);
    end
    faw_cyc = 8'd12;
    #1;
    chk(cfg_err == 1'b0, "R8 faw at limit", 32'(cfg_err), 32'd0);

    // R9: stop inside first sub-loop, finish it, park, restart
    do_reset(4, 20);
    en = 1'b1;
    for (int t = 0; t < 2; t++) @(negedge clk);
    en = 1'b0;
    for (int t = 2; t < 4; t++) begin
      @(negedge clk);
      chk(out_word() == model(t, 4, 20), "R9 finish sub-loop", out_word(), model(t, 4, 20));
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_word() == IDLE_W, "R9 parked", out_word(), IDLE_W);
    end
    en = 1'b1;
    @(negedge clk);
    chk(out_word() == model(0, 4, 20), "R9 restart bank 0", out_word(), model(0, 4, 20));
    for (int t = 1; t < 6; t++) @(negedge clk);
    en = 1'b0;
    for (int t = 6; t < 8; t++) begin
      @(negedge clk);
      chk(out_word() == model(t, 4, 20), "R9 finish second sub-loop", out_word(), model(t, 4, 20));
    end
    @(negedge clk);
    chk(out_word() == IDLE_W, "R9 park before bank 2", out_word(), IDLE_W);

    // R9: stop during padding parks at once
    do_reset(2, 12);
    en = 1'b1;
    for (int t = 0; t < 10; t++) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(out_word() == IDLE_W, "R9 park from padding", out_word(), IDLE_W);
    en = 1'b1;
    @(negedge clk);
    chk(out_word() == model(0, 2, 12), "R9 restart after padding", out_word(), model(0, 2, 12));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule